// File: doc/BRIEF.md
# PHY-to-Link Receive Frame Decoder

This block sits on the link-layer side of a synchronous PHY-to-link interface. On every rising clock edge it samples a 2-bit control bus and an 8-bit data bus, follows the receive sequence the PHY drives, and rebuilds each received packet. Every packet follows the same path, including self-identification packets and the node's own.

For each reception the block reports a speed code on its own output. The code never enters the byte stream, so downstream CRC logic sees only packet data. Packet bytes leave as a strobed stream with first-byte and last-byte markers. A reception that ends before any speed code is reported as a null packet. One-cycle status transfers are captured into a separate status output and do not disturb the reception in progress. Sequence violations raise one-cycle error pulses.

Top module: `phy_rx_decoder`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. After the reset edge every strobe and flag output is 0, `spdRate` is 0 and no partly received byte is kept.
- R2: A reception opens when the control bus shows receive (2'b10) while the data bus carries all ones. While receive holds, the first byte that is not all ones is the speed code. It gives a one-cycle `spdValid` pulse after the edge that sampled it, with `spdRate` equal to the code for values 0 to 4. It never appears on `byteData`.
- R3: A speed code above 4 sets `spdBad` and forces `spdRate` to 7. Both hold until the next speed code. The packet is still framed normally.
- R4: Every byte sampled under receive after the speed code is emitted in order with `byteValid`. A byte comes out after the edge that samples the next control symbol. `byteFirst` marks the first byte of a packet.
- R5: The packet ends when the control bus returns to idle (2'b00). The final byte is emitted after the edge that sampled idle, with `byteLast` set. A one-byte packet carries `byteFirst` and `byteLast` together.
- R6: Receive with all ones followed directly by idle gives a one-cycle `nullPkt` pulse, with no speed pulse and no data bytes.
- R7: A non-all-ones byte under receive with no data-on cycle before it gives a one-cycle `protoErr`. After that the block emits nothing until the control bus returns to idle.
- R8: A status transfer (control 2'b01) lasts one cycle. It gives a one-cycle `statValid` with `statData` equal to the sampled data byte. It does not change the receive sequence in progress.
- R9: Control code 2'b11 during a reception gives a one-cycle `ctlErr`, drops any pending byte and returns to idle. Outside a reception it has no effect.
- R10: A reception that has a speed code but no data bytes, then idle, gives neither a byte nor `nullPkt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| phyCtl | input | 2 | Control bus from the PHY |
| phyData | input | 8 | Data bus from the PHY |
| spdValid | output | 1 | Speed code captured this cycle |
| spdRate | output | 3 | Rate index 0..4, or 7 when the code is unknown |
| spdBad | output | 1 | Last speed code was out of range |
| byteValid | output | 1 | Packet byte strobe |
| byteData | output | 8 | Packet byte |
| byteFirst | output | 1 | First byte of packet |
| byteLast | output | 1 | Last byte of packet |
| nullPkt | output | 1 | Reception ended with no speed code |
| statValid | output | 1 | Status byte captured |
| statData | output | 8 | Captured status byte |
| protoErr | output | 1 | Speed code without prior data-on |
| ctlErr | output | 1 | Illegal control code while receiving |

## Verification
The bench aims at the cases where framing can slip:
- **One-byte packet.** A design that decides "last" too early would drop one of the two markers.
- **Status cycle inside a packet.** A decoder that treated it as data would shift or corrupt the byte stream.
- **Null reception.** A decoder that waited for a speed code would leak a spurious byte or speed pulse.
- **Speed code only, then idle.** Sloppy end handling would emit a phantom byte.
- **Abort with code 11.** A design that keeps the pending byte would emit a stale byte.
- **Speed byte with no data-on cycle.** Without the data-on check the decoder would frame garbage as a packet.

// File: rtl/phy_rx_pkg.sv
package phy_rx_pkg;
  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_STAT = 2'b01;
  localparam logic [1:0] CTL_RECV = 2'b10;
  localparam logic [1:0] CTL_BAD  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATAON,
    ST_DATA,
    ST_SKIP
  } rxState_t;

  typedef struct packed {
    logic spdCap;
    logic dataPush;
    logic flushEnd;
    logic abortPkt;
    logic nullPkt;
    logic protoErr;
    logic ctlErr;
    logic statCap;
  } rxStrobe_t;
endpackage

// File: rtl/phy_rx_ctrl.sv
module phy_rx_ctrl
  import phy_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output rxStrobe_t         str
);
  rxState_t state, nxtState;
  logic     allOnes;

  assign allOnes = &dataIn;

  always_comb begin
    str      = '0;
    nxtState = state;
    if (ctlIn == CTL_STAT) str.statCap = 1'b1;
    case (state)
      ST_IDLE: begin
        if (ctlIn == CTL_RECV) begin
          if (allOnes) nxtState = ST_DATAON;
          else begin
            str.protoErr = 1'b1;
            nxtState     = ST_SKIP;
          end
        end
      end
      ST_DATAON: begin
        case (ctlIn)
          CTL_RECV: if (!allOnes) begin
            str.spdCap = 1'b1;
            nxtState   = ST_DATA;
          end
          CTL_IDLE: begin
            str.nullPkt = 1'b1;
            nxtState    = ST_IDLE;
          end
          CTL_BAD: begin
            str.ctlErr = 1'b1;
            nxtState   = ST_IDLE;
          end
          default: ;
        endcase
      end
      ST_DATA: begin
        case (ctlIn)
          CTL_RECV: str.dataPush = 1'b1;
          CTL_IDLE: begin
            str.flushEnd = 1'b1;
            nxtState     = ST_IDLE;
          end
          CTL_BAD: begin
            str.ctlErr   = 1'b1;
            str.abortPkt = 1'b1;
            nxtState     = ST_IDLE;
          end
          default: ;
        endcase
      end
      ST_SKIP: if (ctlIn == CTL_IDLE) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxtState;
  end

  // R9/R6/R5/R7: at most one framing event per cycle
  p_one_event_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.protoErr, str.ctlErr, str.nullPkt, str.flushEnd, str.spdCap}));

  // R2: a speed code is only taken one or more cycles after a data-on cycle
  p_spd_after_on_r2: assert property (@(posedge clk) disable iff (rst)
    str.spdCap |-> $past(ctlIn) == CTL_RECV || $past(ctlIn) == CTL_STAT);
endmodule

// File: rtl/phy_rx_datapath.sv
module phy_rx_datapath
  import phy_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RATE_W  = 3,
  parameter int MAX_SPD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  rxStrobe_t         str,
  input  logic [DATA_W-1:0] dataIn,
  output logic              spdValid,
  output logic [RATE_W-1:0] spdRate,
  output logic              spdBad,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData,
  output logic              byteFirst,
  output logic              byteLast,
  output logic              nullPkt,
  output logic              statValid,
  output logic [DATA_W-1:0] statData,
  output logic              protoErr,
  output logic              ctlErr
);
  localparam logic [RATE_W-1:0] BAD_RATE = '1;

  logic [DATA_W-1:0] pendData;
  logic              pendValid;
  logic              pendFirst;
  logic              spdKnown;

  assign spdKnown = (dataIn <= DATA_W'(MAX_SPD));

  always_ff @(posedge clk) begin
    if (rst) begin
      spdValid  <= 1'b0;
      spdRate   <= '0;
      spdBad    <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteFirst <= 1'b0;
      byteLast  <= 1'b0;
      nullPkt   <= 1'b0;
      statValid <= 1'b0;
      statData  <= '0;
      protoErr  <= 1'b0;
      ctlErr    <= 1'b0;
      pendData  <= '0;
      pendValid <= 1'b0;
      pendFirst <= 1'b0;
    end else begin
      spdValid  <= str.spdCap;
      byteValid <= 1'b0;
      byteFirst <= 1'b0;
      byteLast  <= 1'b0;
      nullPkt   <= str.nullPkt;
      statValid <= str.statCap;
      protoErr  <= str.protoErr;
      ctlErr    <= str.ctlErr;
      if (str.statCap) statData <= dataIn;
      if (str.spdCap) begin
        spdRate <= spdKnown ? dataIn[RATE_W-1:0] : BAD_RATE;
        spdBad  <= !spdKnown;
      end
      if (str.dataPush) begin
        if (pendValid) begin
          byteValid <= 1'b1;
          byteData  <= pendData;
          byteFirst <= pendFirst;
        end
        pendData  <= dataIn;
        pendFirst <= !pendValid;
        pendValid <= 1'b1;
      end
      if (str.flushEnd) begin
        if (pendValid) begin
          byteValid <= 1'b1;
          byteData  <= pendData;
          byteFirst <= pendFirst;
          byteLast  <= 1'b1;
        end
        pendValid <= 1'b0;
      end
      if (str.abortPkt) pendValid <= 1'b0;
    end
  end

  p_markers_need_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (byteFirst || byteLast) |-> byteValid);

  p_null_alone_r6: assert property (@(posedge clk) disable iff (rst)
    nullPkt |-> !byteValid && !spdValid);

  p_bad_rate_r3: assert property (@(posedge clk) disable iff (rst)
    spdValid |-> (spdBad == (spdRate == BAD_RATE)));

  p_abort_drops_r9: assert property (@(posedge clk) disable iff (rst)
    str.abortPkt |=> !byteValid);
endmodule

// File: rtl/phy_rx_decoder.sv
module phy_rx_decoder
  import phy_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RATE_W  = 3,
  parameter int MAX_SPD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        phyCtl,
  input  logic [DATA_W-1:0] phyData,
  output logic              spdValid,
  output logic [RATE_W-1:0] spdRate,
  output logic              spdBad,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData,
  output logic              byteFirst,
  output logic              byteLast,
  output logic              nullPkt,
  output logic              statValid,
  output logic [DATA_W-1:0] statData,
  output logic              protoErr,
  output logic              ctlErr
);
  rxStrobe_t str;

  phy_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctlIn(phyCtl), .dataIn(phyData), .str(str)
  );

  phy_rx_datapath #(.DATA_W(DATA_W), .RATE_W(RATE_W), .MAX_SPD(MAX_SPD)) u_dp (
    .clk(clk), .rst(rst), .str(str), .dataIn(phyData),
    .spdValid(spdValid), .spdRate(spdRate), .spdBad(spdBad),
    .byteValid(byteValid), .byteData(byteData), .byteFirst(byteFirst),
    .byteLast(byteLast), .nullPkt(nullPkt), .statValid(statValid),
    .statData(statData), .protoErr(protoErr), .ctlErr(ctlErr)
  );
endmodule

// File: tb/phy_rx_decoder_tb.sv
module phy_rx_decoder_tb;
  localparam int VW = 33;
  localparam int NV = 29;

  function automatic logic [VW-1:0] v(input logic [1:0] c, input logic [7:0] d,
      input logic bv, input logic [7:0] bd, input logic bf, input logic bl,
      input logic sv, input logic [2:0] sr, input logic np, input logic pe,
      input logic ce, input logic stv, input logic [3:0] rq);
    return {c, d, bv, bd, bf, bl, sv, sr, np, pe, ce, stv, rq};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    v(2'b00, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1),  // R1 idle
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 2),  // R2 data-on
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 2),
    v(2'b10, 8'h02, 0, 8'h00, 0, 0, 1, 2, 0, 0, 0, 0, 2),  // R2 speed
    v(2'b10, 8'hA1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 4),
    v(2'b10, 8'hB2, 1, 8'hA1, 1, 0, 0, 0, 0, 0, 0, 0, 4),  // R4 first
    v(2'b01, 8'h5C, 0, 8'h5C, 0, 0, 0, 0, 0, 0, 0, 1, 8),  // R8 status mid-packet
    v(2'b10, 8'hC3, 1, 8'hB2, 0, 0, 0, 0, 0, 0, 0, 0, 4),
    v(2'b00, 8'h00, 1, 8'hC3, 0, 1, 0, 0, 0, 0, 0, 0, 5),  // R5 last
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 6),
    v(2'b00, 8'h00, 0, 8'h00, 0, 0, 0, 0, 1, 0, 0, 0, 6),  // R6 null
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 8),
    v(2'b01, 8'h77, 0, 8'h77, 0, 0, 0, 0, 0, 0, 0, 1, 8),  // R8 status in data-on
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 8),
    v(2'b10, 8'h07, 0, 8'h00, 0, 0, 1, 7, 0, 0, 0, 0, 3),  // R3 bad speed
    v(2'b10, 8'h11, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 3),
    v(2'b00, 8'h00, 1, 8'h11, 1, 1, 0, 0, 0, 0, 0, 0, 5),  // R5 single byte
    v(2'b10, 8'h03, 0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 0, 7),  // R7 no data-on
    v(2'b10, 8'h44, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 7),
    v(2'b00, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 7),
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 9),
    v(2'b10, 8'h01, 0, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 9),
    v(2'b10, 8'h55, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 9),
    v(2'b11, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, 9),  // R9 abort
    v(2'b00, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 9),
    v(2'b11, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 9),  // R9 idle, no effect
    v(2'b10, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 10),
    v(2'b10, 8'h04, 0, 8'h00, 0, 0, 1, 4, 0, 0, 0, 0, 10),
    v(2'b00, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 10)  // R10 no byte, no null
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] phyCtl = 2'b00;
  logic [7:0] phyData = 8'h00;
  logic spdValid, spdBad, byteValid, byteFirst, byteLast;
  logic nullPkt, statValid, protoErr, ctlErr;
  logic [2:0] spdRate;
  logic [7:0] byteData, statData;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phy_rx_decoder u_dut (
    .clk(clk), .rst(rst), .phyCtl(phyCtl), .phyData(phyData),
    .spdValid(spdValid), .spdRate(spdRate), .spdBad(spdBad),
    .byteValid(byteValid), .byteData(byteData), .byteFirst(byteFirst),
    .byteLast(byteLast), .nullPkt(nullPkt), .statValid(statValid),
    .statData(statData), .protoErr(protoErr), .ctlErr(ctlErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    phyCtl  = c;
    phyData = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", {spdValid, spdRate, spdBad, byteValid, byteFirst, byteLast,
               nullPkt, statValid, protoErr, ctlErr}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      logic [31:0] act, exp;
      e = VEC[i];
      step(e[32:31], e[30:23]);
      exp = {e[22], (e[22] || e[4]) ? e[21:14] : 8'h00, e[13], e[12], e[11],
             e[11] ? e[10:8] : 3'd0, e[7], e[6], e[5], e[4]};
      act = {byteValid, e[22] ? byteData : (statValid ? statData : 8'h00),
             byteFirst, byteLast, spdValid, spdValid ? spdRate : 3'd0,
             nullPkt, protoErr, ctlErr, statValid};
      chk($sformatf("R%0d row %0d", e[3:0], i), act, exp);
    end

    // R3: out-of-range code held, then cleared by a valid code
    step(2'b10, 8'hFF);
    step(2'b10, 8'h09);
    chk("R3 bad flag", {spdBad, spdRate}, {1'b1, 3'd7});
    step(2'b10, 8'h20);
    step(2'b00, 8'h00);
    chk("R3 still framed", {byteValid, byteData, byteFirst, byteLast}, {1'b1, 8'h20, 2'b11});
    chk("R3 held", {spdBad, spdRate}, {1'b1, 3'd7});
    step(2'b10, 8'hFF);
    step(2'b10, 8'h03);
    chk("R2 good clears", {spdBad, spdRate}, {1'b0, 3'd3});
    step(2'b00, 8'h00);

    // R4: an all-ones byte after the speed code is data
    step(2'b10, 8'hFF);
    step(2'b10, 8'h00);
    step(2'b10, 8'hFF);
    step(2'b10, 8'h12);
    chk("R4 ones as data", {byteValid, byteData, byteFirst}, {1'b1, 8'hFF, 1'b1});
    step(2'b00, 8'h00);
    chk("R4 tail", {byteValid, byteData, byteLast}, {1'b1, 8'h12, 1'b1});

    // R1: reset mid-packet drops pending byte
    step(2'b10, 8'hFF);
    step(2'b10, 8'h02);
    step(2'b10, 8'hAA);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 reset mid", {spdRate, spdBad, byteValid, statData}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    step(2'b00, 8'h00);
    chk("R1 nothing after reset", {byteValid, nullPkt, ctlErr}, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule